// File: doc/BRIEF.md
# Flash Word Program Sequencer

This block writes a run of consecutive words into a parallel NOR-style flash device. The host supplies a base address and a word count, then pulses a start strobe. The block takes one data word at a time from a valid/ready source. For each word it runs the full unlock-and-program command series on a simple bus master port. It then polls the device until the embedded program operation reports completion, reads the word back to verify it, and moves on to the next address.

Polling uses the usual data-polling convention. The polled status bit must match the same bit of the written word. A separate timeout bit lets the block tell a stuck device from a busy one. Any failure stops the run at once. The block then raises an error pulse and reports the address that failed. A clean run ends with a done pulse. In both cases the busy flag falls on the same clock edge as the pulse.

Top module: `flash_prog_ctrl`

## Requirements
- R1: For every word, four bus writes are issued in this order: 0x00AA to address 0x555, 0x0055 to address 0x2AA, 0x00A0 to address 0x555, and then the data word to the target address.
- R2: After the data write, the target address is read repeatedly until bit 7 of the read value equals bit 7 of the written word.
- R3: Once polling matches, exactly one further read of the target address is made, and its full word is compared with the written word.
- R4: Target addresses run from the base address upward in steps of one, covering length words. After the last word verifies, done pulses and no further bus cycle is issued.
- R5: A poll read that shows bit 5 set while bit 7 still mismatches causes exactly one re-read. If bit 7 still mismatches on that re-read, the run ends with error and fail_addr holds that address. If bit 7 matches, verification follows.
- R6: A verify mismatch ends the run with an error pulse and fail_addr set to that address. Done is not asserted, and no bus cycle follows.
- R7: A start pulse that arrives while busy is high is ignored.
- R8: Done and error are single-cycle pulses and are never high together. Busy is low in every cycle in which either one is high.
- R9: Each bus request holds bus_we, bus_addr and bus_wdata stable until bus_ack. Exactly one source word is taken per target address, through a src_valid and src_ready transfer.
- R10: A start with a length of zero produces a done pulse on the next cycle, with no bus cycle and no source transfer.
- R11: After reset, busy, done, error, bus_req and src_ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled while idle |
| base_addr | input | AW | First target word address |
| length | input | LW | Number of words to program |
| src_valid | input | 1 | Source word available |
| src_data | input | DW | Source word |
| src_ready | output | 1 | Source word taken when high with src_valid |
| bus_req | output | 1 | Bus cycle request, held until bus_ack |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Bus word address |
| bus_wdata | output | DW | Bus write data |
| bus_ack | input | 1 | Bus cycle completion, one cycle |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed successfully, one-cycle pulse |
| error | output | 1 | Run aborted, one-cycle pulse |
| fail_addr | output | AW | Address of the word that failed |

## Verification
A sequencer stuck in the wrong state shows up at the bus port within one bus cycle. It can issue a write where a poll read belongs, break the command order seen by the device stub, or keep issuing requests after the terminal pulse. Each of these is caught by the stub's unlock tracker or by its post-termination cycle counter. A wrong poll or timeout decision changes the number of reads per word. A wrong address step or count changes the memory image and the write total. All of these are compared against values worked out from the requirements for each stimulus row.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CMD,
    ST_PGM,
    ST_POLL,
    ST_REPOLL,
    ST_VERIFY
  } fpc_state_e;

  localparam int unsigned NUM_UNLOCK = 3;

  localparam int unsigned KEY_ADDR_A = 'h555;
  localparam int unsigned KEY_ADDR_B = 'h2AA;
  localparam int unsigned KEY_DATA_A = 'hAA;
  localparam int unsigned KEY_DATA_B = 'h55;
  localparam int unsigned KEY_PGM    = 'hA0;

  function automatic int unsigned unlock_addr(input int unsigned idx);
    return (idx == 1) ? KEY_ADDR_B : KEY_ADDR_A;
  endfunction

  function automatic int unsigned unlock_data(input int unsigned idx);
    case (idx)
      0:       return KEY_DATA_A;
      1:       return KEY_DATA_B;
      default: return KEY_PGM;
    endcase
  endfunction

endpackage

// File: rtl/fpc_cmd_gen.sv
module fpc_cmd_gen
  import fpc_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int SW = $clog2(NUM_UNLOCK)
) (
  input  logic [SW-1:0] idx,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);

  logic [AW-1:0] addr_tab [NUM_UNLOCK];
  logic [DW-1:0] data_tab [NUM_UNLOCK];

  for (genvar g = 0; g < NUM_UNLOCK; g++) begin : g_tab
    assign addr_tab[g] = AW'(unlock_addr(g));
    assign data_tab[g] = DW'(unlock_data(g));
  end

  always_comb begin
    cmd_addr = addr_tab[NUM_UNLOCK-1];
    cmd_data = data_tab[NUM_UNLOCK-1];
    for (int i = 0; i < NUM_UNLOCK; i++) begin
      if (idx == SW'(i)) begin
        cmd_addr = addr_tab[i];
        cmd_data = data_tab[i];
      end
    end
  end

endmodule

// File: rtl/fpc_poll_eval.sv
module fpc_poll_eval #(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOUT_BIT = 5
) (
  input  logic [DW-1:0] rd_word,
  input  logic [DW-1:0] exp_word,
  output logic          flag_ok,
  output logic          tout_set,
  output logic          word_ok
);

  initial begin
    assert (POLL_BIT < DW && TOUT_BIT < DW && POLL_BIT != TOUT_BIT)
      else $error("status bit positions out of range");
  end

  assign flag_ok  = (rd_word[POLL_BIT] == exp_word[POLL_BIT]);
  assign tout_set = rd_word[TOUT_BIT];
  assign word_ok  = (rd_word == exp_word);

endmodule

// File: rtl/fpc_bus_master.sv
module fpc_bus_master #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          op_we,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          cmpl,
  output logic [DW-1:0] rd_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      cmpl      <= 1'b0;
      rd_q      <= '0;
    end else begin
      cmpl <= 1'b0;
      if (!bus_req && go) begin
        bus_req   <= 1'b1;
        bus_we    <= op_we;
        bus_addr  <= op_addr;
        bus_wdata <= op_wdata;
      end else if (bus_req && bus_ack) begin
        bus_req <= 1'b0;
        cmpl    <= 1'b1;
        rd_q    <= bus_rdata;
      end
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  assert_cmpl_after_ack_R9: assert property (@(posedge clk) disable iff (rst)
    cmpl |-> $past(bus_ack));

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int AW       = 22,
  parameter int DW       = 16,
  parameter int LW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOUT_BIT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] length,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          src_ready,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] fail_addr
);

  localparam int SW = $clog2(NUM_UNLOCK);

  fpc_state_e    state;
  logic          pend;
  logic [SW-1:0] step;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] remain;
  logic [DW-1:0] cur_data;

  logic          go;
  logic          op_we;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic          cmpl;
  logic [DW-1:0] rd_q;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          flag_ok;
  logic          tout_set;
  logic          word_ok;

  fpc_cmd_gen #(.AW(AW), .DW(DW), .SW(SW)) i_cmd (
    .idx      (step),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data)
  );

  fpc_poll_eval #(.DW(DW), .POLL_BIT(POLL_BIT), .TOUT_BIT(TOUT_BIT)) i_eval (
    .rd_word  (rd_q),
    .exp_word (cur_data),
    .flag_ok  (flag_ok),
    .tout_set (tout_set),
    .word_ok  (word_ok)
  );

  fpc_bus_master #(.AW(AW), .DW(DW)) i_bus (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .op_we     (op_we),
    .op_addr   (op_addr),
    .op_wdata  (op_wdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .cmpl      (cmpl),
    .rd_q      (rd_q)
  );

  assign src_ready = (state == ST_FETCH);

  always_comb begin
    go       = 1'b0;
    op_we    = 1'b0;
    op_addr  = cur_addr;
    op_wdata = cur_data;
    case (state)
      ST_CMD: begin
        go       = !pend;
        op_we    = 1'b1;
        op_addr  = cmd_addr;
        op_wdata = cmd_data;
      end
      ST_PGM: begin
        go    = !pend;
        op_we = 1'b1;
      end
      ST_POLL, ST_REPOLL, ST_VERIFY: go = !pend;
      default: go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= 1'b0;
      step      <= '0;
      cur_addr  <= '0;
      remain    <= '0;
      cur_data  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      fail_addr <= '0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      if (go) pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (length == '0) begin
              done <= 1'b1;
            end else begin
              busy     <= 1'b1;
              cur_addr <= base_addr;
              remain   <= length;
              state    <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (src_valid) begin
            cur_data <= src_data;
            step     <= '0;
            state    <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (cmpl) begin
            pend <= 1'b0;
            if (step == SW'(NUM_UNLOCK-1)) state <= ST_PGM;
            else step <= step + 1'b1;
          end
        end
        ST_PGM: begin
          if (cmpl) begin
            pend  <= 1'b0;
            state <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (cmpl) begin
            pend <= 1'b0;
            if (flag_ok) state <= ST_VERIFY;
            else if (tout_set) state <= ST_REPOLL;
          end
        end
        ST_REPOLL: begin
          if (cmpl) begin
            pend <= 1'b0;
            if (flag_ok) begin
              state <= ST_VERIFY;
            end else begin
              state     <= ST_IDLE;
              busy      <= 1'b0;
              error     <= 1'b1;
              fail_addr <= cur_addr;
            end
          end
        end
        ST_VERIFY: begin
          if (cmpl) begin
            pend <= 1'b0;
            if (!word_ok) begin
              state     <= ST_IDLE;
              busy      <= 1'b0;
              error     <= 1'b1;
              fail_addr <= cur_addr;
            end else if (remain == LW'(1)) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              cur_addr <= cur_addr + 1'b1;
              remain   <= remain - 1'b1;
              state    <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_term_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> !busy);

  assert_term_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && error));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_src_busy_R9: assert property (@(posedge clk) disable iff (rst)
    src_ready |-> busy);

  assert_bus_busy_R6: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

  assert_cmpl_pend_R9: assert property (@(posedge clk) disable iff (rst)
    cmpl |-> pend);

  assert_write_in_seq_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> (bus_we == (state == ST_CMD || state == ST_PGM)));

endmodule

// File: tb/test_flash_prog_ctrl.sv
`timescale 1ns/1ps
module test_flash_prog_ctrl;

  localparam int AW = 22;
  localparam int DW = 16;
  localparam int LW = 16;
  localparam int BUSYP = 3;
  localparam int NV = 5;

  localparam int V_BASE [NV] = '{'h10, 'h20, 'h08, 'h30, 'h18};
  localparam int V_LEN  [NV] = '{1, 4, 3, 2, 3};
  localparam int V_MODE [NV] = '{0, 0, 1, 2, 3};
  localparam int V_FIDX [NV] = '{0, 0, 'h09, 'h30, 'h19};
  localparam int V_ERR  [NV] = '{0, 0, 1, 1, 0};
  localparam int V_NWR  [NV] = '{4, 16, 8, 4, 12};
  localparam int V_NRD  [NV] = '{5, 20, 10, 2, 13};
  localparam int V_NSRC [NV] = '{1, 4, 2, 1, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [LW-1:0] length = '0;
  logic src_valid;
  logic [DW-1:0] src_data;
  logic src_ready, bus_req, bus_we, busy, done, error;
  logic [AW-1:0] bus_addr, fail_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ack;
  logic [DW-1:0] bus_rdata;

  logic [DW-1:0] mem [64];
  int ulk, nwr, nrd, post, busy_left, sidx, fmode, vsel;
  logic seq_err, to_flag, term_seen, wipe;
  logic [DW-1:0] last_d;
  logic [AW-1:0] fidx;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] wordval(input int v, input int i);
    return 16'hA500 ^ 16'(v * 'h31) ^ 16'(i * 'h113);
  endfunction

  assign src_valid = 1'b1;
  assign src_data  = wordval(vsel, sidx);

  flash_prog_ctrl #(.AW(AW), .DW(DW), .LW(LW)) i_flash_prog_ctrl (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .length(length),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .error(error), .fail_addr(fail_addr)
  );

  // behavioural flash stub
  always @(posedge clk) begin
    if (rst || wipe) begin
      for (int k = 0; k < 64; k++) mem[k] <= 16'hFFFF;
      ulk <= 0; seq_err <= 1'b0; nwr <= 0; nrd <= 0; post <= 0;
      busy_left <= 0; to_flag <= 1'b0; bus_ack <= 1'b0; sidx <= 0;
      term_seen <= 1'b0; bus_rdata <= '0; last_d <= '0;
    end else begin
      bus_ack <= 1'b0;
      if (done || error) term_seen <= 1'b1;
      if (src_valid && src_ready) sidx <= sidx + 1;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        if (term_seen) post <= post + 1;
        if (bus_we) begin
          nwr <= nwr + 1;
          if (ulk == 3) begin
            mem[bus_addr[5:0]] <= (fmode == 1 && bus_addr == fidx) ? (bus_wdata ^ 16'h0001) : bus_wdata;
            last_d <= bus_wdata;
            ulk <= 0;
            busy_left <= (fmode == 2 && bus_addr == fidx) ? 1000 :
                         (fmode == 3 && bus_addr == fidx) ? 1 : BUSYP;
            to_flag <= (fmode >= 2 && bus_addr == fidx);
          end else if (ulk == 0 && bus_addr == 22'h555 && bus_wdata == 16'h00AA) ulk <= 1;
          else if (ulk == 1 && bus_addr == 22'h2AA && bus_wdata == 16'h0055) ulk <= 2;
          else if (ulk == 2 && bus_addr == 22'h555 && bus_wdata == 16'h00A0) ulk <= 3;
          else begin
            seq_err <= 1'b1;
            ulk <= 0;
          end
        end else begin
          nrd <= nrd + 1;
          if (busy_left > 0) begin
            bus_rdata <= {8'h00, ~last_d[7], 1'b0, to_flag, 5'h00};
            busy_left <= busy_left - 1;
          end else begin
            bus_rdata <= mem[bus_addr[5:0]];
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_stub(input int mode, input int fa, input int v);
    @(negedge clk);
    wipe = 1'b1; fmode = mode; fidx = AW'(fa); vsel = v;
    @(negedge clk);
    wipe = 1'b0;
  endtask

  task automatic pulse_start(input int b, input int l);
    @(negedge clk);
    start = 1'b1; base_addr = AW'(b); length = LW'(l);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_term(output bit got_done, output bit got_err, output bit busy_at);
    got_done = 1'b0; got_err = 1'b0; busy_at = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      if (done || error) break;
      @(negedge clk);
    end
    got_done = done; got_err = error; busy_at = busy;
    check(got_done || got_err, "R4 run terminates", 0, 1);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit gd, ge, ba;
    wipe = 1'b0; fmode = 0; fidx = '0; vsel = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!busy && !done && !error, "R11 status low", {busy, done, error}, 0);
    check(!bus_req && !src_ready, "R11 bus/source idle", {bus_req, src_ready}, 0);

    for (int v = 0; v < NV; v++) begin
      clear_stub(V_MODE[v], V_FIDX[v], v);
      pulse_start(V_BASE[v], V_LEN[v]);
      wait_term(gd, ge, ba);
      check(ge == V_ERR[v][0], "R6 error outcome", ge, V_ERR[v]);
      check(gd == !V_ERR[v][0], "R4 done outcome", gd, !V_ERR[v][0]);
      check(!ba, "R8 busy low with pulse", ba, 0);
      if (V_ERR[v] != 0) check(fail_addr == AW'(V_FIDX[v]), "R5 R6 fail_addr", fail_addr, V_FIDX[v]);
      @(negedge clk);
      check(!done && !error, "R8 pulse width one", {done, error}, 0);
      repeat (10) @(negedge clk);
      check(!seq_err, "R1 unlock order", seq_err, 0);
      check(nwr == V_NWR[v], "R1 write count", nwr, V_NWR[v]);
      check(nrd == V_NRD[v], "R2 R3 R5 read count", nrd, V_NRD[v]);
      check(post == 0, "R4 R6 no bus after end", post, 0);
      check(sidx == V_NSRC[v], "R9 source transfers", sidx, V_NSRC[v]);
      for (int i = 0; i < V_LEN[v]; i++) begin
        int a;
        logic [DW-1:0] e;
        a = V_BASE[v] + i;
        if (i >= V_NSRC[v]) e = 16'hFFFF;
        else if (V_MODE[v] == 1 && a == V_FIDX[v]) e = wordval(v, i) ^ 16'h0001;
        else e = wordval(v, i);
        check(mem[a[5:0]] == e, "R4 memory image", mem[a[5:0]], e);
      end
    end

    // R10 zero length
    clear_stub(0, 0, 7);
    @(negedge clk);
    start = 1'b1; base_addr = AW'('h10); length = '0;
    @(negedge clk);
    start = 1'b0;
    check(done && !busy, "R10 immediate done", {done, busy}, 2);
    repeat (5) @(negedge clk);
    check(nwr + nrd == 0, "R10 no bus cycle", nwr + nrd, 0);
    check(sidx == 0, "R10 no source transfer", sidx, 0);

    // R7 start while busy ignored
    clear_stub(0, 0, 9);
    pulse_start('h28, 2);
    repeat (6) @(negedge clk);
    check(busy, "R7 busy mid run", busy, 1);
    start = 1'b1; base_addr = '0; length = LW'(5);
    @(negedge clk);
    start = 1'b0;
    wait_term(gd, ge, ba);
    check(gd && !ge, "R7 first run completes", {gd, ge}, 2);
    repeat (10) @(negedge clk);
    check(nwr == 8, "R7 write count", nwr, 8);
    check(mem[0] == 16'hFFFF, "R7 ignored base untouched", mem[0], 16'hFFFF);
    check(mem['h29] == wordval(9, 1), "R7 original run data", mem['h29], wordval(9, 1));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule